// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Unit

This block sits next to a small processor core and decides when execution must be redirected to an interrupt handler. It keeps one pending flag for each interrupt source. A pending source is eligible only when its own enable bit is set, the global enable is set and the program-counter gate is open. Among the eligible sources the one with the lowest index wins. The unit then presents a take-interrupt request, the winner's index and the handler address to the core.

Each vector slot is two program words wide. Slot 0 holds the reset vector and source `i` uses slot `i+1`. The table starts at address 0 or, when relocation is selected, at a boot start address given by a parameter. A separate configuration input moves only the reset vector to that boot address.

When the core takes the interrupt it pulses an acknowledge. On that acknowledge the unit clears the winner's pending flag and the global enable. Software may set the global enable again inside a handler to allow nesting. A return-from-interrupt indication from the core restores the global enable automatically. When the lock input is set and the program counter lies in the boot region, no interrupt is requested. Requests that arrive while the unit cannot take them stay pending until they are serviced.

Top module: `irq_vector_unit`

## Requirements
- R1: During and directly after reset, every pending flag is 0, the global enable is 0, the take request is 0 and the reset vector output is 0.
- R2: A 1 on bit `i` of `req_set_i` sets pending flag `i` at the next clock edge. The flag stays set until an accepted acknowledge for source `i`, even while the global enable is 0.
- R3: `irq_req_o` rises one clock edge after some pending source has its enable bit at 1 while the global enable is 1 and the gate is open. It drops one edge after no source meets these conditions.
- R4: Priority is fixed: the lowest-indexed eligible source is reported on `irq_id_o`. A higher-priority request that becomes eligible before the acknowledge replaces the current winner.
- R5: `irq_vec_o` equals the table base plus 2*(id+1). The table base is 0 when `vec_sel_i`=0 and `BOOT_BASE` when `vec_sel_i`=1.
- R6: `reset_vec_o` is registered. It equals `BOOT_BASE` when `rst_boot_i`=1 and 0 otherwise.
- R7: An acknowledge while `irq_req_o`=1 does three things at the next edge: it clears the pending flag of the reported source, clears the global enable and drops `irq_req_o`. An acknowledge outweighs every other input that acts on the global enable.
- R8: After a clock edge with `reti_i`=1 or `gie_set_i`=1 (and no accepted acknowledge), the global enable is 1. `gie_clr_i` alone clears it. A set wins over a clear in the same cycle.
- R9: While `lock_en_i`=1 and `pc_i` >= `BOOT_BASE`, `irq_req_o` is 0 one edge later and the pending flags are kept.
- R10: An acknowledge while `irq_req_o`=0 changes neither the pending flags nor the global enable.
- R11: After an acknowledge, setting the global enable again lets an enabled source request a new interrupt while the first handler is still running (nesting).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set_i | input | NUM_SRC | One bit per source; a 1 sets that source's pending flag |
| src_en_i | input | NUM_SRC | Per-source enable bits |
| gie_set_i | input | 1 | Software sets the global enable |
| gie_clr_i | input | 1 | Software clears the global enable |
| reti_i | input | 1 | Core is executing a return-from-interrupt |
| ack_i | input | 1 | One-cycle pulse from the core when it takes the interrupt |
| pc_i | input | PC_W | Current program counter (word address) |
| vec_sel_i | input | 1 | Relocates the interrupt table to BOOT_BASE |
| rst_boot_i | input | 1 | Moves the reset vector to BOOT_BASE |
| lock_en_i | input | 1 | Enables program-counter gating of interrupts |
| irq_req_o | output | 1 | Take-interrupt request to the core |
| irq_id_o | output | IDX_W | Index of the winning source |
| irq_vec_o | output | PC_W | Handler address of the winning source |
| reset_vec_o | output | PC_W | Current reset vector address |
| gie_o | output | 1 | Global enable state |
| pending_o | output | NUM_SRC | Pending flags |

## Verification
The assertions take for granted that every control input is synchronous to `clk` and that `ack_i` stands for a real take only while `irq_req_o` is high. An acknowledge with no request is allowed, but it must be ignored. The randomized stimulus drives `ack_i` only in cycles where it has just seen `irq_req_o` high. A directed case issues a deliberate stray acknowledge to cover R10. Relocation, reset-vector selection, lock and program counter are randomized freely, because the unit has to follow them at any cycle.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_ON   = 2'd1,
    GIE_OFF  = 2'd2
  } gie_op_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] pend_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_o[g] <= 1'b0;
      end else if (set_i[g]) begin
        pend_o[g] <= 1'b1;
      end else if (clr_i[g]) begin
        pend_o[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/irqv_gie.sv
module irqv_gie
  import irqv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic reti_i,
  input  logic set_i,
  input  logic clr_i,
  output logic gie_o
);

  gie_op_e op;

  always_comb begin
    if (take_i) begin
      op = GIE_OFF;
    end else if (reti_i || set_i) begin
      op = GIE_ON;
    end else if (clr_i) begin
      op = GIE_OFF;
    end else begin
      op = GIE_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_o <= 1'b0;
    end else begin
      case (op)
        GIE_ON:  gie_o <= 1'b1;
        GIE_OFF: gie_o <= 1'b0;
        default: gie_o <= gie_o;
      endcase
    end
  end

endmodule

// File: rtl/irqv_vecgen.sv
module irqv_vecgen #(
  parameter int              PC_W      = 16,
  parameter int              IDX_W     = 3,
  parameter logic [PC_W-1:0] BOOT_BASE = 16'h3800
) (
  input  logic             vec_sel_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             lock_en_i,
  output logic [PC_W-1:0]  addr_o,
  output logic             blocked_o
);

  localparam int STRIDE_SHIFT = 1;

  logic [PC_W-1:0] base;
  logic [PC_W-1:0] slot;

  always_comb begin
    base      = vec_sel_i ? BOOT_BASE : '0;
    slot      = PC_W'(idx_i) + PC_W'(1);
    addr_o    = base + (slot << STRIDE_SHIFT);
    blocked_o = lock_en_i && (pc_i >= BOOT_BASE);
  end

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int              NUM_SRC   = 8,
  parameter int              PC_W      = 16,
  parameter logic [PC_W-1:0] BOOT_BASE = 16'h3800,
  localparam int             IDX_W     = irqv_pkg::idx_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_set_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               ack_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               vec_sel_i,
  input  logic               rst_boot_i,
  input  logic               lock_en_i,
  output logic               irq_req_o,
  output logic [IDX_W-1:0]   irq_id_o,
  output logic [PC_W-1:0]    irq_vec_o,
  output logic [PC_W-1:0]    reset_vec_o,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] pending_o
);

  logic               take;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] eligible;
  logic               any_win;
  logic [IDX_W-1:0]   win_idx;
  logic [PC_W-1:0]    win_addr;
  logic               blocked;

  assign take = ack_i && irq_req_o;

  always_comb begin
    clr_mask = '0;
    if (take) begin
      clr_mask[irq_id_o] = 1'b1;
    end
  end

  irqv_pending #(.NUM_SRC(NUM_SRC)) pend_i (
    .clk    (clk),
    .rst    (rst),
    .set_i  (req_set_i),
    .clr_i  (clr_mask),
    .pend_o (pending_o)
  );

  irqv_gie gie_i (
    .clk    (clk),
    .rst    (rst),
    .take_i (take),
    .reti_i (reti_i),
    .set_i  (gie_set_i),
    .clr_i  (gie_clr_i),
    .gie_o  (gie_o)
  );

  irqv_vecgen #(.PC_W(PC_W), .IDX_W(IDX_W), .BOOT_BASE(BOOT_BASE)) vgen_i (
    .vec_sel_i (vec_sel_i),
    .idx_i     (win_idx),
    .pc_i      (pc_i),
    .lock_en_i (lock_en_i),
    .addr_o    (win_addr),
    .blocked_o (blocked)
  );

  assign eligible = pending_o & src_en_i & {NUM_SRC{gie_o && !blocked}};

  irqv_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) arb_i (
    .req_i (eligible),
    .any_o (any_win),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_o   <= 1'b0;
      irq_id_o    <= '0;
      irq_vec_o   <= '0;
      reset_vec_o <= '0;
    end else begin
      irq_req_o   <= any_win && !take;
      irq_id_o    <= win_idx;
      irq_vec_o   <= win_addr;
      reset_vec_o <= rst_boot_i ? BOOT_BASE : '0;
    end
  end

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int              NUM_SRC   = 8,
  parameter int              PC_W      = 16,
  parameter logic [PC_W-1:0] BOOT_BASE = 16'h3800,
  parameter int              IDX_W     = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_set_i,
  input logic [NUM_SRC-1:0] src_en_i,
  input logic               reti_i,
  input logic               ack_i,
  input logic [PC_W-1:0]    pc_i,
  input logic               vec_sel_i,
  input logic               rst_boot_i,
  input logic               lock_en_i,
  input logic               irq_req_o,
  input logic [IDX_W-1:0]   irq_id_o,
  input logic [PC_W-1:0]    irq_vec_o,
  input logic [PC_W-1:0]    reset_vec_o,
  input logic               gie_o,
  input logic [NUM_SRC-1:0] pending_o
);

  logic [NUM_SRC-1:0] below_id;
  logic [PC_W-1:0]    slot_off;

  always_comb begin
    for (int j = 0; j < NUM_SRC; j++) begin
      below_id[j] = (j < int'(irq_id_o));
    end
    slot_off = (PC_W'(irq_id_o) + PC_W'(1)) << 1;
  end

  assert_req_needs_gie_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> $past(gie_o));

  assert_no_higher_winner_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (($past(pending_o & src_en_i) & below_id) == '0));

  assert_vec_addr_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> (irq_vec_o == (($past(vec_sel_i) ? BOOT_BASE : PC_W'(0)) + slot_off)));

  assert_reset_vec_R6: assert property (@(posedge clk) disable iff (rst)
    rst_boot_i |=> (reset_vec_o == BOOT_BASE));

  assert_ack_clears_gie_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_req_o) |=> (!gie_o && !irq_req_o));

  assert_ack_single_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_req_o) |=> ($countones($past(pending_o) & ~pending_o) <= 1));

  assert_reti_sets_gie_R8: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !(ack_i && irq_req_o)) |=> gie_o);

  assert_pending_kept_R2: assert property (@(posedge clk) disable iff (rst)
    !(ack_i && irq_req_o) |=> ((pending_o & $past(pending_o)) == $past(pending_o)));

  assert_new_req_latched_R2: assert property (@(posedge clk) disable iff (rst)
    (req_set_i != '0) |=> ((pending_o & $past(req_set_i)) == $past(req_set_i)));

  assert_gate_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (lock_en_i && (pc_i >= BOOT_BASE)) |=> !irq_req_o);

  assert_stray_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !irq_req_o && !reti_i) |=> (gie_o == $past(gie_o) || gie_o));

endmodule

bind irq_vector_unit irqv_checker #(
  .NUM_SRC   (NUM_SRC),
  .PC_W      (PC_W),
  .BOOT_BASE (BOOT_BASE),
  .IDX_W     (IDX_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_set_i   (req_set_i),
  .src_en_i    (src_en_i),
  .reti_i      (reti_i),
  .ack_i       (ack_i),
  .pc_i        (pc_i),
  .vec_sel_i   (vec_sel_i),
  .rst_boot_i  (rst_boot_i),
  .lock_en_i   (lock_en_i),
  .irq_req_o   (irq_req_o),
  .irq_id_o    (irq_id_o),
  .irq_vec_o   (irq_vec_o),
  .reset_vec_o (reset_vec_o),
  .gie_o       (gie_o),
  .pending_o   (pending_o)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb_top;

  localparam int              N     = 8;
  localparam int              PW    = 16;
  localparam logic [PW-1:0]   BOOT  = 16'h3800;
  localparam int              IW    = 3;
  localparam int              WDOG  = 60000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_set = '0;
  logic [N-1:0]  src_en = '1;
  logic          gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0, ack = 1'b0;
  logic [PW-1:0] pc = '0;
  logic          vec_sel = 1'b0, rst_boot = 1'b0, lock_en = 1'b0;
  logic          irq_req;
  logic [IW-1:0] irq_id;
  logic [PW-1:0] irq_vec, reset_vec;
  logic          gie;
  logic [N-1:0]  pending;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  irq_vector_unit #(.NUM_SRC(N), .PC_W(PW), .BOOT_BASE(BOOT)) dut_i (
    .clk(clk), .rst(rst), .req_set_i(req_set), .src_en_i(src_en),
    .gie_set_i(gie_set), .gie_clr_i(gie_clr), .reti_i(reti), .ack_i(ack),
    .pc_i(pc), .vec_sel_i(vec_sel), .rst_boot_i(rst_boot), .lock_en_i(lock_en),
    .irq_req_o(irq_req), .irq_id_o(irq_id), .irq_vec_o(irq_vec),
    .reset_vec_o(reset_vec), .gie_o(gie), .pending_o(pending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] vec_of(input int id, input logic sel);
    return (sel ? BOOT : PW'(0)) + PW'(2 * (id + 1));
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    int r = 0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  // Reference model built from the requirements, advanced at each rising edge.
  logic [N-1:0]  m_pend;
  logic          m_gie, m_req;
  int            m_id;
  logic [PW-1:0] m_vec, m_rvec;

  always @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; m_gie <= 1'b0; m_req <= 1'b0; m_id <= 0; m_vec <= '0; m_rvec <= '0;
    end else begin
      logic          take;
      logic [N-1:0]  clr, elig;
      take = ack && m_req;
      clr  = take ? (N'(1) << m_id) : '0;
      elig = m_pend & src_en & {N{m_gie && !(lock_en && pc >= BOOT)}};
      m_pend <= (m_pend & ~clr) | req_set;
      if (take) m_gie <= 1'b0;
      else if (reti || gie_set) m_gie <= 1'b1;
      else if (gie_clr) m_gie <= 1'b0;
      m_req  <= (elig != '0) && !take;
      m_id   <= lowest(elig);
      m_vec  <= vec_of(lowest(elig), vec_sel);
      m_rvec <= rst_boot ? BOOT : PW'(0);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 model pending", 32'(pending), 32'(m_pend));
      chk("R8 model gie", 32'(gie), 32'(m_gie));
      chk("R3 model irq_req", 32'(irq_req), 32'(m_req));
      chk("R6 model reset_vec", 32'(reset_vec), 32'(m_rvec));
      if (m_req) begin
        chk("R4 model irq_id", 32'(irq_id), 32'(m_id));
        chk("R5 model irq_vec", 32'(irq_vec), 32'(m_vec));
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=%0d expected<=%0d", cyc, WDOG);
      summary();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 pending", 32'(pending), 0);
    chk("R1 gie", 32'(gie), 0);
    chk("R1 irq_req", 32'(irq_req), 0);
    chk("R1 reset_vec", 32'(reset_vec), 0);

    // R2 requests kept while global enable is low
    req_set = 8'h24; step(1); req_set = '0; step(3);
    chk("R2 held pending", 32'(pending), 32'h24);
    chk("R3 no req without gie", 32'(irq_req), 0);

    // R3 / R5 enable global, lowest of {2,5} wins
    gie_set = 1'b1; step(1); gie_set = 1'b0; step(1);
    chk("R3 irq_req", 32'(irq_req), 1);
    chk("R4 id of 2", 32'(irq_id), 2);
    chk("R5 vec low table", 32'(irq_vec), 32'(vec_of(2, 1'b0)));

    // R4 higher priority arrives before acknowledge
    req_set = 8'h01; step(1); req_set = '0; step(1);
    chk("R4 preempt id", 32'(irq_id), 0);
    chk("R5 vec id0", 32'(irq_vec), 32'h2);

    // R5 table relocation
    vec_sel = 1'b1; step(1);
    chk("R5 relocated vec", 32'(irq_vec), 32'(BOOT + 16'd2));

    // R7 acknowledge
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R7 pending cleared", 32'(pending), 32'h24);
    chk("R7 gie cleared", 32'(gie), 0);
    chk("R7 req dropped", 32'(irq_req), 0);

    // R10 stray acknowledge
    ack = 1'b1; step(1); ack = 1'b0; step(1);
    chk("R10 pending unchanged", 32'(pending), 32'h24);
    chk("R10 gie unchanged", 32'(gie), 0);

    // R11 nesting: take 2, re-enable inside handler, source 1 preempts
    gie_set = 1'b1; step(1); gie_set = 1'b0; step(1);
    chk("R11 first req id", 32'(irq_id), 2);
    ack = 1'b1; step(1); ack = 1'b0;
    gie_set = 1'b1; req_set = 8'h02; step(1); gie_set = 1'b0; req_set = '0; step(1);
    chk("R11 nested req", 32'(irq_req), 1);
    chk("R11 nested id", 32'(irq_id), 1);
    chk("R11 nested vec", 32'(irq_vec), 32'(vec_of(1, 1'b1)));

    // R8 return restores global enable
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R8 gie off after ack", 32'(gie), 0);
    reti = 1'b1; step(1); reti = 1'b0;
    chk("R8 reti restores gie", 32'(gie), 1);
    gie_clr = 1'b1; gie_set = 1'b1; step(1); gie_clr = 1'b0; gie_set = 1'b0;
    chk("R8 set beats clear", 32'(gie), 1);

    // R9 program-counter gate
    lock_en = 1'b1; pc = BOOT + 16'd5; step(3);
    chk("R9 gated req", 32'(irq_req), 0);
    chk("R9 pending kept", 32'(pending), 32'h20);
    pc = 16'h0010; step(1);
    chk("R9 gate open req", 32'(irq_req), 1);
    chk("R9 gate open id", 32'(irq_id), 5);
    lock_en = 1'b0;

    // R3 per-source enable
    src_en = 8'hDF; step(1);
    chk("R3 source disabled", 32'(irq_req), 0);
    src_en = '1;

    // R6 reset vector relocation
    rst_boot = 1'b1; step(1);
    chk("R6 boot reset vec", 32'(reset_vec), 32'(BOOT));
    rst_boot = 1'b0; step(1);
    chk("R6 low reset vec", 32'(reset_vec), 0);

    // Randomized phase
    for (int k = 0; k < 4000; k++) begin
      req_set  = N'($urandom & $urandom & $urandom);
      src_en   = ($urandom % 4 == 0) ? N'($urandom) : '1;
      gie_set  = ($urandom % 6 == 0);
      gie_clr  = ($urandom % 10 == 0);
      reti     = ($urandom % 12 == 0);
      ack      = irq_req && ($urandom % 3 == 0);
      pc       = ($urandom % 3 == 0) ? PW'($urandom) : PW'($urandom % 256);
      lock_en  = ($urandom % 3 == 0);
      vec_sel  = ($urandom % 4 == 0) ? ~vec_sel : vec_sel;
      rst_boot = ($urandom % 5 == 0) ? ~rst_boot : rst_boot;
      step(1);
    end
    req_set = '0; ack = 1'b0; gie_set = 1'b0; gie_clr = 1'b0; reti = 1'b0;
    step(2);
    summary();
  end

endmodule